// File: doc/BRIEF.md
# Dual-Clock Debug Register Bridge

This block is a small bank of debug registers reachable from both a JTAG test access port and a CPU control-register bus. The JTAG side runs on TCK, with its own reset and a standard sixteen-state TAP controller. The CPU side runs on the peripheral clock. The bank holds an instruction register and a 32-bit data register. The CPU can access the data register whole or as two 16-bit halves. The bank also holds a one-bit bypass path and an interrupt-source register. Each register has its own width and access rights on each side.

An external debugger uses the interrupt instruction to raise a flag on the CPU side. The flag drives an interrupt request until the CPU clears it. The event that sets the flag is a toggle in the TCK domain. A synchronizer chain in the peripheral-clock domain carries it across and turns it into one set pulse per command. The design relies on TCK being slower than the peripheral clock.

Top module: `jdbg_bridge`

## Requirements
- R1: After both resets, a CPU read at byte offset 0x00 returns 0x0000FFFF, a read at offset 0x14 returns 0x00000000, and `irq` is low.
- R2: In Capture-IR the instruction shift path always loads 0xFFFFFFFD. It is shifted out on TDO least significant bit first, whatever instruction is currently loaded.
- R3: Update-IR loads the 32 bits shifted in. A CPU read at offset 0x00 returns bits [31:16] of the loaded instruction in rdata[15:0]. CPU writes to offset 0x00 have no effect.
- R4: Any loaded instruction other than the interrupt code 0x5A000000 selects the one-bit bypass path. The path captures 0, and in Shift-DR TDO repeats TDI one TCK cycle later.
- R5: Five TCK cycles with TMS high put the TAP in Test-Logic-Reset. That state resets the instruction to all ones, so the CPU reads 0xFFFF at offset 0x00 and bypass is selected. Asserting the active-low `trst_n` does the same.
- R6: An Update-IR that loads the interrupt code 0x5A000000 sets bit 0 of the interrupt-source register, which is read at offset 0x14. `irq` then goes high within a few peripheral-clock cycles. Each such command gives exactly one set event.
- R7: A CPU write to offset 0x14 with wdata[0]=0 clears the flag and `irq`. A write with wdata[0]=1 has no effect. If a set event and a clear arrive in the same cycle, the set wins.
- R8: With the interrupt instruction loaded, the data path is 32 bits wide and write-only from JTAG. Shifting it returns all zeros, and shifting it does not set the flag.
- R9: The data register is read and written as 32 bits at offset 0x08 when `bus_wide`=1. With `bus_wide`=0, offset 0x08 reaches bits [31:16] and offset 0x0A reaches bits [15:0], both through bits [15:0] of the bus with the upper read bits zero. A narrow write changes only the half it addresses.
- R10: TDO changes only on the falling edge of TCK, and it is 0 in every state other than Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock for the CPU side |
| rst_n | input | 1 | Active-low reset of the CPU side |
| bus_en | input | 1 | CPU access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 5 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 for unmapped offsets |
| irq | output | 1 | Interrupt request, level of the flag |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Active-low TAP reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out |

## Verification
The bench builds the block with SYNC_STAGES=3, which selects the longer synchronizer chain, and keeps the 32-bit instruction width and the default interrupt code. The longer chain stretches the delay from Update-IR to `irq`, so the bench has to poll for the request instead of expecting it in a fixed cycle. A second interrupt command with the toggle back at its old level shows that each command gives one set event. The default 32-bit widths let the bench compare the fixed capture word and the all-zero interrupt path bit for bit.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

   typedef enum logic [3:0] {
      TAP_RESET, TAP_IDLE,
      TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR, TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR,
      TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
   } tap_state_t;

   typedef enum logic {PATH_BYPASS, PATH_INTSRC} dr_path_t;

   localparam int ADDR_W = 5;
   localparam int BUS_W  = 32;
   localparam int HALF_W = BUS_W / 2;

   localparam logic [ADDR_W-1:0] OFS_INSTR = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DATHI = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_DATLO = 5'h0A;
   localparam logic [ADDR_W-1:0] OFS_INTSR = 5'h14;

endpackage

// File: rtl/jdbg_tap_ctrl.sv
module jdbg_tap_ctrl
   import jdbg_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         TAP_RESET:    nxt = tms ? TAP_RESET    : TAP_IDLE;
         TAP_IDLE:     nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
         TAP_SEL_DR:   nxt = tms ? TAP_SEL_IR   : TAP_CAP_DR;
         TAP_CAP_DR:   nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
         TAP_SHIFT_DR: nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
         TAP_EXIT1_DR: nxt = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
         TAP_PAUSE_DR: nxt = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
         TAP_EXIT2_DR: nxt = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
         TAP_UPD_DR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
         TAP_SEL_IR:   nxt = tms ? TAP_RESET    : TAP_CAP_IR;
         TAP_CAP_IR:   nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
         TAP_SHIFT_IR: nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
         TAP_EXIT1_IR: nxt = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
         TAP_PAUSE_IR: nxt = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
         TAP_EXIT2_IR: nxt = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
         TAP_UPD_IR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
         default:      nxt = TAP_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TAP_RESET;
      else         state <= nxt;
   end

   // R5: five TMS-high cycles reach Test-Logic-Reset from anywhere; the last step checked here
   assert_sel_ir_exit_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_SEL_IR && tms) |=> (state == TAP_RESET));

endmodule

// File: rtl/jdbg_shift_paths.sv
module jdbg_shift_paths
   import jdbg_pkg::*;
#(
   parameter int             IR_W       = 32,
   parameter int             INT_W      = 32,
   parameter logic [IR_W-1:0] IR_CAPTURE = 32'hFFFF_FFFD,
   parameter logic [IR_W-1:0] INT_CODE   = 32'h5A00_0000
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic            tdo,
   output logic [IR_W-1:0] ir_q,
   output logic            int_toggle
);

   logic [IR_W-1:0]  ir_sr;
   logic [INT_W-1:0] int_sr;
   logic             bp_q;
   dr_path_t         path;

   generate
      if (IR_W < HALF_W) begin : g_bad_ir
         $error("IR_W must cover the CPU view of the instruction");
      end
      if (INT_W < 1) begin : g_bad_int
         $error("INT_W must be at least 1");
      end
   endgenerate

   assign path = (ir_q == INT_CODE) ? PATH_INTSRC : PATH_BYPASS;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr      <= '1;
         ir_q       <= '1;
         bp_q       <= 1'b0;
         int_sr     <= '0;
         int_toggle <= 1'b0;
      end else begin
         unique case (state)
            TAP_RESET: begin
               ir_sr <= '1;
               ir_q  <= '1;
            end
            TAP_CAP_IR:   ir_sr <= IR_CAPTURE;
            TAP_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            TAP_UPD_IR: begin
               ir_q <= ir_sr;
               if (ir_sr == INT_CODE) int_toggle <= ~int_toggle;
            end
            TAP_CAP_DR: begin
               if (path == PATH_BYPASS) bp_q   <= 1'b0;
               else                     int_sr <= '0;
            end
            TAP_SHIFT_DR: begin
               if (path == PATH_BYPASS) bp_q <= tdi;
               else if (INT_W == 1)     int_sr <= tdi;
               else                     int_sr <= {tdi, int_sr[INT_W-1:1]};
            end
            default: ;
         endcase
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo <= 1'b0;
      end else begin
         unique case (state)
            TAP_SHIFT_IR: tdo <= ir_sr[0];
            TAP_SHIFT_DR: tdo <= (path == PATH_BYPASS) ? bp_q : int_sr[0];
            default:      tdo <= 1'b0;
         endcase
      end
   end

   assert_capture_fixed_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_CAP_IR) |=> (ir_sr == IR_CAPTURE));

   assert_tlr_clears_ir_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_RESET) |=> (ir_q == '1));

   assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_CAP_DR && path == PATH_BYPASS) |=> !bp_q);

   assert_int_path_zero_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_CAP_DR && path == PATH_INTSRC) |=> (int_sr == '0));

endmodule

// File: rtl/jdbg_event_sync.sv
module jdbg_event_sync #(
   parameter int STAGES = 2
)(
   input  logic pclk,
   input  logic rst_n,
   input  logic toggle_in,
   output logic pulse
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge pclk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= toggle_in;
            end
         end else begin : g_rest
            always_ff @(posedge pclk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign pulse = chain[STAGES-1] ^ last_q;

   // R6: one toggle gives one pulse, never a run of them
   assert_single_pulse_R6: assert property (@(posedge pclk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/jdbg_cpu_regs.sv
module jdbg_cpu_regs
   import jdbg_pkg::*;
(
   input  logic              pclk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic              bus_wide,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [HALF_W-1:0] ir_view,
   input  logic              set_pulse,
   output logic              irq
);

   logic [BUS_W-1:0] dreg;
   logic             flag;
   logic             wr, wr_int, wr_hi, wr_lo;

   assign wr     = bus_en && bus_we;
   assign wr_int = wr && (bus_addr == OFS_INTSR);
   assign wr_hi  = wr && (bus_addr == OFS_DATHI);
   assign wr_lo  = wr && (bus_addr == OFS_DATLO) && !bus_wide;

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n)                        flag <= 1'b0;
      else if (set_pulse)                flag <= 1'b1;
      else if (wr_int && !bus_wdata[0])  flag <= 1'b0;
   end

   always_ff @(posedge pclk) begin
      if (wr_hi && bus_wide) begin
         dreg <= bus_wdata;
      end else if (wr_hi) begin
         dreg[BUS_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
      end else if (wr_lo) begin
         dreg[HALF_W-1:0] <= bus_wdata[HALF_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_INSTR: bus_rdata[HALF_W-1:0] = ir_view;
         OFS_DATHI: begin
            if (bus_wide) bus_rdata = dreg;
            else          bus_rdata[HALF_W-1:0] = dreg[BUS_W-1:HALF_W];
         end
         OFS_DATLO: if (!bus_wide) bus_rdata[HALF_W-1:0] = dreg[HALF_W-1:0];
         OFS_INTSR: bus_rdata[0] = flag;
         default: ;
      endcase
   end

   assign irq = flag;

   assert_set_wins_R7: assert property (@(posedge pclk) disable iff (!rst_n)
      set_pulse |=> irq);

   assert_clear_R7: assert property (@(posedge pclk) disable iff (!rst_n)
      (wr_int && !bus_wdata[0] && !set_pulse) |=> !irq);

   assert_only_jtag_sets_R6: assert property (@(posedge pclk) disable iff (!rst_n)
      (!irq && !set_pulse) |=> !irq);

endmodule

// File: rtl/jdbg_bridge.sv
module jdbg_bridge
   import jdbg_pkg::*;
#(
   parameter int              IR_W        = 32,
   parameter int              INT_W       = 32,
   parameter int              SYNC_STAGES = 2,
   parameter logic [IR_W-1:0] IR_CAPTURE  = 32'hFFFF_FFFD,
   parameter logic [IR_W-1:0] INT_CODE    = 32'h5A00_0000
)(
   input  logic        pclk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic        bus_wide,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   input  logic        tck,
   input  logic        trst_n,
   input  logic        tms,
   input  logic        tdi,
   output logic        tdo
);

   localparam int VIEW_LSB = IR_W - HALF_W;

   tap_state_t      state;
   logic [IR_W-1:0] ir_q;
   logic            int_toggle;
   logic            set_pulse;

   jdbg_tap_ctrl u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   jdbg_shift_paths #(
      .IR_W       (IR_W),
      .INT_W      (INT_W),
      .IR_CAPTURE (IR_CAPTURE),
      .INT_CODE   (INT_CODE)
   ) u_paths (
      .tck        (tck),
      .trst_n     (trst_n),
      .state      (state),
      .tdi        (tdi),
      .tdo        (tdo),
      .ir_q       (ir_q),
      .int_toggle (int_toggle)
   );

   jdbg_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .pclk      (pclk),
      .rst_n     (rst_n),
      .toggle_in (int_toggle),
      .pulse     (set_pulse)
   );

   jdbg_cpu_regs u_regs (
      .pclk      (pclk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_wide  (bus_wide),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ir_view   (ir_q[IR_W-1:VIEW_LSB]),
      .set_pulse (set_pulse),
      .irq       (irq)
   );

   // R10: TDO is 0 in any non-shift state, sampled just before the rising edge
   assert_tdo_idle_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_IDLE && $past(state) == TAP_IDLE) |-> !tdo);

endmodule

// File: tb/test_jdbg_bridge.sv
module test_jdbg_bridge;

   localparam int PCLK_PERIOD = 10;
   localparam int TCK_PERIOD  = 40;
   localparam logic [31:0] INT_CMD = 32'h5A00_0000;

   logic        pclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic        tdo;

   int n_checks = 0;
   int n_errors = 0;

   jdbg_bridge #(.SYNC_STAGES(3)) i_jdbg_bridge (
      .pclk(pclk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo)
   );

   always #(PCLK_PERIOD/2) pclk = ~pclk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tck_cycle(input logic m, input logic d);
      tms = m;
      tdi = d;
      #(TCK_PERIOD/2) tck = 1'b1;
      #(TCK_PERIOD/2) tck = 1'b0;
      #2;
   endtask

   task automatic cpu_write(input logic [4:0] a, input logic w, input logic [31:0] d);
      @(negedge pclk);
      bus_en = 1'b1; bus_we = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
      @(negedge pclk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic cpu_read(input logic [4:0] a, input logic w, output logic [31:0] d);
      @(negedge pclk);
      bus_en = 1'b1; bus_we = 1'b0; bus_wide = w; bus_addr = a;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic tap_reset_to_idle();
      for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0);
      tck_cycle(1'b0, 1'b0);
   endtask

   // from Run-Test/Idle: shift 32 bits into IR, update, back to idle
   task automatic load_ir(input logic [31:0] din, output logic [31:0] dout);
      tck_cycle(1'b1, 1'b0); tck_cycle(1'b1, 1'b0);
      tck_cycle(1'b0, 1'b0); tck_cycle(1'b0, 1'b0);
      for (int i = 0; i < 32; i++) begin
         dout[i] = tdo;
         tck_cycle(i == 31, din[i]);
      end
      tck_cycle(1'b1, 1'b0);
      tck_cycle(1'b0, 1'b0);
   endtask

   task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      tck_cycle(1'b1, 1'b0); tck_cycle(1'b0, 1'b0); tck_cycle(1'b0, 1'b0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tck_cycle(i == n - 1, din[i]);
      end
      tck_cycle(1'b1, 1'b0);
      tck_cycle(1'b0, 1'b0);
   endtask

   task automatic wait_irq(input int limit);
      for (int i = 0; i < limit; i++) begin
         if (irq) break;
         @(negedge pclk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] r;
      trst_n = 1'b0; rst_n = 1'b0;
      repeat (4) @(negedge pclk);
      trst_n = 1'b1; rst_n = 1'b1;
      tap_reset_to_idle();
      cpu_read(5'h00, 1'b0, r); check("R1 instr reset", r, 32'h0000_FFFF);
      cpu_read(5'h14, 1'b0, r); check("R1 intsrc reset", r, 32'h0);
      check("R1 irq reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_ir_capture();
      logic [31:0] cap, r;
      load_ir(32'h1234_5678, cap);
      check("R2 capture after reset", cap, 32'hFFFF_FFFD);
      repeat (4) @(negedge pclk);
      cpu_read(5'h00, 1'b0, r); check("R3 cpu view of instr", r, 32'h0000_1234);
      cpu_write(5'h00, 1'b0, 32'h0000_AAAA);
      cpu_read(5'h00, 1'b0, r); check("R3 cpu write ignored", r, 32'h0000_1234);
      load_ir(32'h0000_0001, cap);
      check("R2 capture with other instr", cap, 32'hFFFF_FFFD);
   endtask

   task automatic t_bypass();
      logic [31:0] o;
      shift_dr(8, 32'h0000_00B2, o);
      check("R4 bypass one-bit delay", o, 32'h0000_0064);
      check("R10 tdo zero in idle", {31'b0, tdo}, 32'h0);
   endtask

   task automatic t_tdo_edge();
      // enter Shift-DR with bypass selected (instr 0x00000001)
      tck_cycle(1'b1, 1'b0); tck_cycle(1'b0, 1'b0); tck_cycle(1'b0, 1'b0);
      check("R10 tdo captured bypass bit", {31'b0, tdo}, 32'h0);
      tms = 1'b0; tdi = 1'b1;
      #(TCK_PERIOD/2) tck = 1'b1;
      #(TCK_PERIOD/4);
      check("R10 tdo holds through rising edge", {31'b0, tdo}, 32'h0);
      #(TCK_PERIOD/4) tck = 1'b0;
      #2;
      check("R10 tdo moves on falling edge", {31'b0, tdo}, 32'h1);
      tck_cycle(1'b1, 1'b0); tck_cycle(1'b1, 1'b0); tck_cycle(1'b0, 1'b0);
   endtask

   task automatic t_tlr();
      logic [31:0] r, o;
      tap_reset_to_idle();
      repeat (4) @(negedge pclk);
      cpu_read(5'h00, 1'b0, r); check("R5 tlr restores instr", r, 32'h0000_FFFF);
      shift_dr(4, 32'h0000_0005, o);
      check("R5 bypass after tlr", o, 32'h0000_000A);
   endtask

   task automatic t_interrupt();
      logic [31:0] cap, r;
      load_ir(INT_CMD, cap);
      wait_irq(30);
      check("R6 irq raised", {31'b0, irq}, 32'h1);
      cpu_read(5'h14, 1'b0, r); check("R6 intsrc bit0 set", r, 32'h1);
      cpu_write(5'h14, 1'b0, 32'h1);
      cpu_read(5'h14, 1'b0, r); check("R7 write of one ignored", r, 32'h1);
      cpu_write(5'h14, 1'b0, 32'h0);
      cpu_read(5'h14, 1'b0, r); check("R7 clear by cpu", r, 32'h0);
      repeat (30) @(negedge pclk);
      check("R6 single set per command", {31'b0, irq}, 32'h0);
      load_ir(INT_CMD, cap);
      wait_irq(30);
      check("R6 second command sets again", {31'b0, irq}, 32'h1);
      cpu_write(5'h14, 1'b0, 32'h0);
      check("R7 irq low after clear", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_int_path();
      logic [31:0] o;
      shift_dr(32, 32'hFFFF_FFFF, o);
      check("R8 write-only path reads zero", o, 32'h0);
      repeat (30) @(negedge pclk);
      check("R8 shift does not set flag", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_data_reg();
      logic [31:0] r;
      cpu_write(5'h08, 1'b1, 32'hDEAD_BEEF);
      cpu_read(5'h08, 1'b1, r); check("R9 wide readback", r, 32'hDEAD_BEEF);
      cpu_read(5'h08, 1'b0, r); check("R9 high half", r, 32'h0000_DEAD);
      cpu_read(5'h0A, 1'b0, r); check("R9 low half", r, 32'h0000_BEEF);
      cpu_write(5'h0A, 1'b0, 32'h0000_1234);
      cpu_read(5'h08, 1'b1, r); check("R9 low write keeps high", r, 32'hDEAD_1234);
      cpu_write(5'h08, 1'b0, 32'h0000_5678);
      cpu_read(5'h08, 1'b1, r); check("R9 high write keeps low", r, 32'h5678_1234);
   endtask

   initial begin
      t_reset();
      t_ir_capture();
      t_bypass();
      t_tdo_edge();
      t_tlr();
      t_interrupt();
      t_int_path();
      t_data_reg();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(PCLK_PERIOD * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule